// File: doc/BRIEF.md
# SDRAM Single-Read Command Sequencer

This block sits on the controller side of a mobile SDRAM and carries out one isolated read per request. A request names a bank, a row and a column. The sequencer opens the row with ACTIVE and waits out the row-to-column delay. It then issues READ with auto-precharge disabled and captures the single returned word after the CAS latency. It closes the row with an explicit PRECHARGE, and it keeps the array busy until the row-cycle and precharge rules allow the next ACTIVE. Every cycle that carries no command drives NOP.

The burst length is one and no auto-precharge is used. The sequencer holds the PRECHARGE back until the minimum active time has run since ACTIVE, and fills the cycles in between with NOPs. All delays are parameters in whole clocks. With `PRE_AT = max(T_RAS, T_RCD+1)` and `NEXT_AT = max(PRE_AT+T_RP, T_RC, PRE_AT+2)`, measured in cycles after ACTIVE, the PRECHARGE falls in cycle `PRE_AT` and the next ACTIVE is possible in cycle `NEXT_AT`.

The states are IDLE, ACT, RCD_WAIT, READ, RAS_WAIT, PRE and RP_WAIT. The transitions are:
- IDLE goes to ACT on an accepted request.
- ACT goes to READ when T_RCD is 1, and to RCD_WAIT otherwise.
- RCD_WAIT goes to READ in cycle T_RCD-1.
- READ goes to PRE when PRE_AT is T_RCD+1, and to RAS_WAIT otherwise.
- RAS_WAIT goes to PRE in cycle PRE_AT-1.
- PRE goes to IDLE when NEXT_AT is PRE_AT+2, and to RP_WAIT otherwise.
- RP_WAIT goes to IDLE in cycle NEXT_AT-2.

Top module: `sdr_rd_seq`

## Requirements
- R1: After reset, and in every cycle while idle, the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), busy is low, rd_valid is low and every sd_dqm bit is 1.
- R2: A req seen while idle produces ACTIVE (cs_n=0, ras_n=0, cas_n=1, we_n=1) in the next cycle, with sd_addr equal to the row and sd_ba equal to the bank.
- R3: READ (cs_n=0, ras_n=1, cas_n=0, we_n=1) is issued exactly T_RCD cycles after ACTIVE. sd_addr carries the column in its low COL_W bits, bit 10 (the auto-precharge bit) is 0 and all other bits are 0. sd_ba is the bank and sd_dqm is all zeros in that cycle.
- R4: PRECHARGE (cs_n=0, ras_n=0, cas_n=1, we_n=0) is issued exactly PRE_AT cycles after ACTIVE. sd_addr bit 10 equals PRE_ALL_BANKS, all other address bits are 0, and sd_ba is the bank.
- R5: Every other cycle of an access carries NOP.
- R6: rd_valid is a one-cycle pulse CAS_LAT+1 cycles after the READ cycle. rd_data then holds the dq_in value present in cycle READ+CAS_LAT.
- R7: busy is high from the ACTIVE cycle through cycle NEXT_AT-2 after ACTIVE, and low from cycle NEXT_AT-1 onward.
- R8: A req raised while busy is ignored: no extra command is issued, and the access in progress keeps its own bank, row and column.
- R9: A request made in the first idle cycle gives an ACTIVE exactly NEXT_AT cycles after the previous ACTIVE, and never sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Read request strobe |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| busy | output | 1 | Sequencer occupied; requests ignored |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Multiplexed address bus |
| sd_ba | output | BANK_W | Bank select |
| sd_dqm | output | DATA_W/8 | Byte masks, high = output disabled |
| dq_in | input | DATA_W | Read data from the memory |
| rd_data | output | DATA_W | Captured read word |
| rd_valid | output | 1 | One-cycle pulse: rd_data is new |

## Verification
The checker's own count of cycles since ACTIVE lets the assertions check several rules on every cycle. They cover the ACTIVE-to-READ spacing, the PRECHARGE cycle, the ACTIVE-to-ACTIVE gap, the cleared auto-precharge bit on READ, NOP while idle, ACTIVE only in answer to an accepted request, and the single-cycle valid pulse. Other behaviour can only be shown by the bench scenarios: that the captured word is the one the memory model returned for that bank, row and column at the right latency, that a request poked mid-access leaves the bank and row untouched, and that back-to-back requests land exactly on the cycle gap. Those scenarios sweep all banks over corner row and column values.

// File: rtl/sdr_rd_pkg.sv
`timescale 1ns/1ps
package sdr_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_RCD,
        ST_READ,
        ST_RAS,
        ST_PRE,
        ST_RP
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_ACT = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
    localparam sd_cmd_t CMD_RD  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
    localparam sd_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};

    localparam int AP_BIT = 10;

endpackage

// File: rtl/sdr_span_counter.sv
`timescale 1ns/1ps
module sdr_span_counter #(
    parameter int W   = 4,
    parameter int MAX = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= LIMIT;
        end else if (clear) begin
            count <= '0;
        end else if (count != LIMIT) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sdr_rd_capture.sv
`timescale 1ns/1ps
module sdr_rd_capture #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              inflight,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [CAS_LAT-1:0] pipe;

    generate
        if (CAS_LAT == 1) begin : g_lat1
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= issue;
            end
        end else begin : g_latn
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[CAS_LAT-2:0], issue};
            end
        end
    endgenerate

    assign inflight = |pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= pipe[CAS_LAT-1];
            if (pipe[CAS_LAT-1]) rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdr_cmd_drive.sv
`timescale 1ns/1ps
module sdr_cmd_drive
    import sdr_rd_pkg::*;
#(
    parameter int BANK_W        = 2,
    parameter int ROW_W         = 12,
    parameter int COL_W         = 9,
    parameter int DQM_W         = 2,
    parameter bit PRE_ALL_BANKS = 1'b0
) (
    input  seq_state_t        state,
    input  logic              inflight,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [COL_W-1:0]  col_q,
    output sd_cmd_t           cmd,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic [DQM_W-1:0]  sd_dqm
);
    always_comb begin
        cmd     = CMD_NOP;
        sd_addr = '0;
        sd_ba   = '0;
        unique case (state)
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_addr = row_q;
                sd_ba   = bank_q;
            end
            ST_READ: begin
                cmd                 = CMD_RD;
                sd_addr[COL_W-1:0]  = col_q;
                sd_addr[AP_BIT]     = 1'b0;
                sd_ba               = bank_q;
            end
            ST_PRE: begin
                cmd             = CMD_PRE;
                sd_addr[AP_BIT] = PRE_ALL_BANKS;
                sd_ba           = bank_q;
            end
            ST_IDLE, ST_RCD, ST_RAS, ST_RP: begin
                cmd = CMD_NOP;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
        sd_dqm = (state == ST_READ || inflight) ? '0 : '1;
    end
endmodule

// File: rtl/sdr_rd_seq.sv
`timescale 1ns/1ps
module sdr_rd_seq
    import sdr_rd_pkg::*;
#(
    parameter int BANK_W        = 2,
    parameter int ROW_W         = 12,
    parameter int COL_W         = 9,
    parameter int DATA_W        = 16,
    parameter int T_RCD         = 3,
    parameter int T_RAS         = 6,
    parameter int T_RP          = 3,
    parameter int T_RC          = 10,
    parameter int CAS_LAT       = 2,
    parameter bit PRE_ALL_BANKS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              busy,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic [DATA_W/8-1:0] sd_dqm,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int DQM_W   = DATA_W / 8;
    localparam int PRE_AT  = (T_RAS > T_RCD + 1) ? T_RAS : T_RCD + 1;
    localparam int NEXT_A  = PRE_AT + T_RP;
    localparam int NEXT_B  = (NEXT_A > T_RC) ? NEXT_A : T_RC;
    localparam int NEXT_AT = (NEXT_B > PRE_AT + 2) ? NEXT_B : PRE_AT + 2;
    localparam int CNT_W   = $clog2(NEXT_AT + 1);

    localparam logic [CNT_W-1:0] RCD_LAST = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] RAS_LAST = CNT_W'(PRE_AT - 1);
    localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(NEXT_AT - 2);

    seq_state_t        state, state_nx;
    logic [CNT_W-1:0]  since_act;
    logic              accept;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              inflight;
    sd_cmd_t           cmd;

    assign accept = req && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                bank_q <= req_bank;
                row_q  <= req_row;
                col_q  <= req_col;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_ACT;
            ST_ACT:  state_nx = (T_RCD <= 1) ? ST_READ : ST_RCD;
            ST_RCD:  if (since_act == RCD_LAST) state_nx = ST_READ;
            ST_READ: state_nx = (PRE_AT == T_RCD + 1) ? ST_PRE : ST_RAS;
            ST_RAS:  if (since_act == RAS_LAST) state_nx = ST_PRE;
            ST_PRE:  state_nx = (NEXT_AT == PRE_AT + 2) ? ST_IDLE : ST_RP;
            ST_RP:   if (since_act == RP_LAST) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    sdr_span_counter #(
        .W   (CNT_W),
        .MAX (NEXT_AT)
    ) span_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .count (since_act)
    );

    sdr_cmd_drive #(
        .BANK_W        (BANK_W),
        .ROW_W         (ROW_W),
        .COL_W         (COL_W),
        .DQM_W         (DQM_W),
        .PRE_ALL_BANKS (PRE_ALL_BANKS)
    ) drive_i (
        .state    (state),
        .inflight (inflight),
        .bank_q   (bank_q),
        .row_q    (row_q),
        .col_q    (col_q),
        .cmd      (cmd),
        .sd_addr  (sd_addr),
        .sd_ba    (sd_ba),
        .sd_dqm   (sd_dqm)
    );

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;

    sdr_rd_capture #(
        .DATA_W  (DATA_W),
        .CAS_LAT (CAS_LAT)
    ) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (state == ST_READ),
        .dq_in    (dq_in),
        .inflight (inflight),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/sdr_rd_seq_chk.sv
`timescale 1ns/1ps
module sdr_rd_seq_chk #(
    parameter int BANK_W        = 2,
    parameter int ROW_W         = 12,
    parameter int T_RCD         = 3,
    parameter int T_RAS         = 6,
    parameter int T_RP          = 3,
    parameter int T_RC          = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              busy,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ROW_W-1:0]  sd_addr,
    input logic [BANK_W-1:0] sd_ba,
    input logic              rd_valid
);
    localparam int PRE_AT  = (T_RAS > T_RCD + 1) ? T_RAS : T_RCD + 1;
    localparam int NEXT_A  = PRE_AT + T_RP;
    localparam int NEXT_B  = (NEXT_A > T_RC) ? NEXT_A : T_RC;
    localparam int NEXT_AT = (NEXT_B > PRE_AT + 2) ? NEXT_B : PRE_AT + 2;
    localparam int CW      = $clog2(NEXT_AT + 1);

    logic is_act, is_rd, is_pre, is_nop;
    logic [CW-1:0] since;

    assign is_act = ({cs_n, ras_n, cas_n, we_n} == 4'b0011);
    assign is_rd  = ({cs_n, ras_n, cas_n, we_n} == 4'b0101);
    assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
    assign is_nop = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);

    always_ff @(posedge clk) begin
        if (!rst_n)                    since <= CW'(NEXT_AT);
        else if (is_act)               since <= CW'(1);
        else if (since != CW'(NEXT_AT)) since <= since + 1'b1;
    end

    p_idle_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> is_nop);
    p_act_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> ($past(req) && !$past(busy)));
    p_rcd_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> (since == CW'(T_RCD)));
    p_rd_no_ap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> !sd_addr[10]);
    p_pre_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (since == CW'(PRE_AT)));
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> !is_act);
    p_rc_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since == CW'(NEXT_AT)));
endmodule

bind sdr_rd_seq sdr_rd_seq_chk #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .T_RCD  (T_RCD),
    .T_RAS  (T_RAS),
    .T_RP   (T_RP),
    .T_RC   (T_RC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .busy     (busy),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .sd_addr  (sd_addr),
    .sd_ba    (sd_ba),
    .rd_valid (rd_valid)
);

// File: tb/sdr_rd_seq_tb.sv
`timescale 1ns/1ps
module sdr_rd_seq_tb_top;
    localparam int BANK_W = 2, ROW_W = 12, COL_W = 9, DATA_W = 16;
    localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RC = 10, CL = 2;
    localparam int PRE_AT  = (T_RAS > T_RCD + 1) ? T_RAS : T_RCD + 1;
    localparam int NEXT_AT = ((PRE_AT + T_RP > T_RC) ? PRE_AT + T_RP : T_RC) > PRE_AT + 2 ?
                             ((PRE_AT + T_RP > T_RC) ? PRE_AT + T_RP : T_RC) : PRE_AT + 2;
    localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, PRE = 4'b0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic busy, cs_n, ras_n, cas_n, we_n, rd_valid;
    logic [ROW_W-1:0]  sd_addr;
    logic [BANK_W-1:0] sd_ba;
    logic [1:0]        sd_dqm;
    logic [DATA_W-1:0] dq_in, rd_data;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    sdr_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .busy(busy),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm),
        .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // memory model: CAS latency 2, word built from bank, open row and column
    logic [ROW_W-1:0]  open_row [4];
    logic              m0 = 1'b0, m1 = 1'b0;
    logic [DATA_W-1:0] m0d = '0, m1d = '0;
    always @(posedge clk) begin
        if ({cs_n, ras_n, cas_n, we_n} == ACT) open_row[sd_ba] <= sd_addr;
        m0  <= ({cs_n, ras_n, cas_n, we_n} == RD);
        m0d <= {sd_ba, open_row[sd_ba][4:0], sd_addr[8:0]};
        m1  <= m0;
        m1d <= m0d;
    end
    assign dq_in = m1 ? m1d : 16'hDEAD;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // called at a negedge with the sequencer idle
    task automatic run_read(input logic [1:0] b, input logic [ROW_W-1:0] r,
                            input logic [COL_W-1:0] c, input logic poke);
        logic [3:0] ecmd;
        logic [ROW_W-1:0] eaddr;
        req = 1'b1; req_bank = b; req_row = r; req_col = c;
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= NEXT_AT; k++) begin
            ecmd = NOP; eaddr = '0;
            if (k == 1)               begin ecmd = ACT; eaddr = r; end
            else if (k == 1 + T_RCD)  begin ecmd = RD;  eaddr = {3'b000, c}; end
            else if (k == 1 + PRE_AT) begin ecmd = PRE; eaddr = '0; end
            if (k == 1)
                check({cs_n, ras_n, cas_n, we_n} == ecmd && sd_addr == eaddr && sd_ba == b,
                      "R2 active", {16'(sd_addr), 12'(sd_ba), cs_n, ras_n, cas_n, we_n},
                      {16'(eaddr), 12'(b), ecmd});
            else if (k == 1 + T_RCD)
                check({cs_n, ras_n, cas_n, we_n} == ecmd && sd_addr == eaddr && sd_ba == b && sd_dqm == 2'b00,
                      "R3 read", {16'(sd_addr), 10'(sd_ba), sd_dqm, cs_n, ras_n, cas_n, we_n},
                      {16'(eaddr), 10'(b), 2'b00, ecmd});
            else if (k == 1 + PRE_AT)
                check({cs_n, ras_n, cas_n, we_n} == ecmd && sd_addr == eaddr && sd_ba == b,
                      "R4 R8 precharge", {16'(sd_addr), 12'(sd_ba), cs_n, ras_n, cas_n, we_n},
                      {16'(eaddr), 12'(b), ecmd});
            else
                check({cs_n, ras_n, cas_n, we_n} == NOP, "R5 R8 nop",
                      32'({cs_n, ras_n, cas_n, we_n}), 32'(NOP));
            check(busy == (k < NEXT_AT), "R7 busy", 32'(busy), 32'(k < NEXT_AT));
            if (k == 2 + T_RCD + CL)
                check(rd_valid && rd_data == {b, r[4:0], c}, "R6 data",
                      {15'(rd_valid), rd_data}, {15'd1, b, r[4:0], c});
            else
                check(!rd_valid, "R6 pulse", 32'(rd_valid), 32'd0);
            if (poke && k == 3) begin
                req = 1'b1; req_bank = b + 2'd1; req_row = ~r; req_col = ~c;
            end else begin
                req = 1'b0;
            end
            if (k < NEXT_AT) @(negedge clk);
        end
        req = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [ROW_W-1:0] rows [3];
        logic [COL_W-1:0] cols [3];
        rows[0] = '0; rows[1] = '1; rows[2] = 12'h5A3;
        cols[0] = '0; cols[1] = '1; cols[2] = 9'h0A5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({cs_n, ras_n, cas_n, we_n} == NOP && !busy && !rd_valid && sd_dqm == 2'b11,
              "R1 reset", {busy, rd_valid, sd_dqm, cs_n, ras_n, cas_n, we_n}, {4'b0011, NOP});
        for (int b = 0; b < 4; b++) begin
            for (int ri = 0; ri < 3; ri++) begin
                for (int ci = 0; ci < 3; ci++) begin
                    if (ci == 0) begin
                        // idle gap: R1 NOP and low busy while idle
                        for (int g = 0; g < 3; g++) begin
                            @(negedge clk);
                            check({cs_n, ras_n, cas_n, we_n} == NOP && !busy && sd_dqm == 2'b11,
                                  "R1 idle", {busy, sd_dqm, cs_n, ras_n, cas_n, we_n}, {3'b011, NOP});
                        end
                    end
                    // back-to-back when ci != 0: R9 gap equals NEXT_AT
                    run_read(2'(b), rows[ri], cols[ci], ri == 1);
                end
            end
        end
        @(negedge clk);
        check(!busy && !rd_valid, "R1 final idle", {busy, rd_valid}, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule